// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block spreads DRAM refresh work evenly over the retention window. It issues one request per fixed interval, so every row is revisited once per retention period. It does not refresh all rows in one burst. A free-running interval timer fires every `floor(RETENTION_NS * CLK_MHZ / (1000 * ROWS))` clock cycles. Rounding down keeps the refresh rate on the safe side. With 256 rows, a 4 ms window and a 200 MHz clock, the interval is 3125 cycles, which is 15.625 µs. A row counter names the row to refresh next. It steps through the rows in ascending order and wraps to 0 after the last row. With 256 rows the counter is 8 bits wide and wraps from 255 to 0.

The memory controller sees `refresh_req` together with `refresh_row`. It performs the refresh, then pulses `refresh_done` for one cycle. `owed_cnt` is the number of refreshes that have come due and are not yet done. If the timer fires again while a request is still open, the owed count grows and `overdue` is raised. Each later completion pays back one owed refresh.

A three-state machine holds the request state:
- **IDLE**: nothing is owed.
- **PENDING**: exactly one refresh is owed.
- **BEHIND**: two or more refreshes are owed.

Its transitions are:
- *expire*: IDLE→PENDING, or PENDING→BEHIND.
- *serve*: PENDING→IDLE, or BEHIND→PENDING once the count drops back to one.
- *expire-and-serve*: the timer fires and a completion arrives in the same cycle. The state does not change.

BEHIND also holds through any expiry or completion that leaves two or more owed.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval is `INTERVAL = floor(RETENTION_NS*CLK_MHZ/(1000*ROWS))` clock cycles. The timer starts counting at reset release. Its first expiry takes effect at the INTERVAL-th rising edge after release, and later expiries follow every INTERVAL edges.
- R2: `refresh_req` goes high on the edge where an expiry finds nothing owed. It stays high until every owed refresh has been completed.
- R3: `refresh_row` starts at 0. It steps by +1 per accepted completion and wraps from ROWS-1 to 0. It is always less than ROWS.
- R4: A completion is accepted when `refresh_done` is high while `refresh_req` is high. On the next edge the row advances and `owed_cnt` drops by one. Without an accepted completion the row does not change.
- R5: An expiry while a request is open raises `owed_cnt` by one. `overdue` is high exactly when `owed_cnt` is 2 or more.
- R6: `refresh_done` while `refresh_req` is low is ignored: the row and the owed count are unchanged.
- R7: An expiry and an accepted completion on the same edge leave `owed_cnt` unchanged, and the row still advances.
- R8: `owed_cnt` saturates at MAX_OWED. An expiry that finds the count saturated is not counted.
- R9: While `rst_n` is low, `refresh_req`, `overdue`, `owed_cnt` and `refresh_row` are all 0, and the timer restarts on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_done | input | 1 | One-cycle completion pulse from the memory controller |
| refresh_req | output | 1 | A refresh is owed |
| refresh_row | output | $clog2(ROWS) | Row to refresh next |
| overdue | output | 1 | Two or more refreshes are owed |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes due and not yet done |

## Verification
Every output is registered, so the effect of an expiry or a completion appears one edge after the edge that samples it. The bench drives `refresh_done` at falling edges and samples one falling edge after the rising edge on which the effect is due. Each table entry states how many idle edges pass before an optional one-edge completion pulse. The expected values are then worked out from the edge count since reset: expiries land on edges 10, 20, 30 and so on for the bench's 10-cycle interval. The directed part uses this same timing to test the row wrap, saturation, and a reset in the middle of a run.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    // Request state of the refresh backlog
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // nothing owed
        ST_PENDING = 2'd1,   // exactly one refresh owed
        ST_BEHIND  = 2'd2    // two or more owed
    } owe_state_t;

    // Interval in cycles, rounded down (never refreshes too slowly)
    function automatic longint unsigned interval_cycles(
        input longint unsigned ret_ns,
        input longint unsigned clk_mhz,
        input longint unsigned rows
    );
        return (ret_ns * clk_mhz) / (64'd1000 * rows);
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire
);
    localparam int TIMER_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TIMER_W-1:0] LAST = TIMER_W'(INTERVAL - 1);

    logic [TIMER_W-1:0] count_q;

    assign expire = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (expire)
            count_q <= '0;
        else
            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
    parameter int ROWS  = 256,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (step)
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/refresh_backlog_fsm.sv
module refresh_backlog_fsm
    import refresh_pkg::*;
#(
    parameter int MAX_OWED = 15,
    parameter int OWED_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              done,
    output logic              req,
    output logic              late,
    output logic              accept,
    output logic [OWED_W-1:0] owed
);
    localparam logic [OWED_W-1:0] OWED_TOP = OWED_W'(MAX_OWED);

    owe_state_t        state_q, state_d;
    logic [OWED_W-1:0] owed_d;
    logic              grow;

    // Output process: all outputs decoded from the state
    always_comb begin
        req    = (state_q != ST_IDLE);
        late   = (state_q == ST_BEHIND);
        accept = done && (state_q != ST_IDLE);
    end

    // Owed count update: a saturated expiry is dropped
    always_comb begin
        grow   = expire && (owed != OWED_TOP);
        owed_d = owed;
        unique case ({grow, accept})
            2'b10:   owed_d = owed + 1'b1;
            2'b01:   owed_d = owed - 1'b1;
            default: owed_d = owed;
        endcase
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (expire)                       // expire
                    state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (expire && !accept)            // expire
                    state_d = ST_BEHIND;
                else if (accept && !expire)       // serve
                    state_d = ST_IDLE;
            end
            ST_BEHIND: begin
                if (owed_d == OWED_W'(1))         // serve back to one owed
                    state_d = ST_PENDING;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owed    <= '0;
        end else begin
            state_q <= state_d;
            owed    <= owed_d;
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refresh_pkg::*;
#(
    parameter int ROWS         = 256,
    parameter int RETENTION_NS = 4000000,
    parameter int CLK_MHZ      = 200,
    parameter int MAX_OWED     = 15,
    localparam int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int OWED_W      = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_done,
    output logic              refresh_req,
    output logic [ROW_W-1:0]  refresh_row,
    output logic              overdue,
    output logic [OWED_W-1:0] owed_cnt
);
    localparam int INTERVAL = int'(interval_cycles(
        64'(RETENTION_NS), 64'(CLK_MHZ), 64'(ROWS)));

    logic expire;
    logic accept;

    refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire)
    );

    refresh_backlog_fsm #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .done   (refresh_done),
        .req    (refresh_req),
        .late   (overdue),
        .accept (accept),
        .owed   (owed_cnt)
    );

    refresh_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .row   (refresh_row)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int ROWS     = 256,
    parameter int MAX_OWED = 15,
    parameter int ROW_W    = 8,
    parameter int OWED_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              refresh_done,
    input logic              refresh_req,
    input logic [ROW_W-1:0]  refresh_row,
    input logic              overdue,
    input logic [OWED_W-1:0] owed_cnt
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && !refresh_done) |=> refresh_req);                       // R2
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_row <= LAST_ROW);                                              // R3
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_done && refresh_req) |=>
        (refresh_row == (($past(refresh_row) == LAST_ROW) ? '0 : $past(refresh_row) + 1'b1))); // R4
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(refresh_done && refresh_req) |=> $stable(refresh_row));              // R6
    AST_OVERDUE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        overdue |-> refresh_req);                                              // R5
    AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_cnt > $past(owed_cnt)) |-> (owed_cnt == $past(owed_cnt) + 1'b1)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        owed_cnt <= OWED_W'(MAX_OWED));                                        // R8
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .ROWS(ROWS), .MAX_OWED(MAX_OWED), .ROW_W(ROW_W), .OWED_W(OWED_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .refresh_done(refresh_done),
    .refresh_req(refresh_req), .refresh_row(refresh_row),
    .overdue(overdue), .owed_cnt(owed_cnt)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    // 8 rows, 400 ns, 200 MHz -> interval of 10 cycles
    localparam int ROWS = 8;
    localparam int MAXO = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_done = 1'b0;
    logic       refresh_req;
    logic [2:0] refresh_row;
    logic       overdue;
    logic [1:0] owed_cnt;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(.ROWS(ROWS), .RETENTION_NS(400), .CLK_MHZ(200),
                         .MAX_OWED(MAXO)) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .refresh_done(refresh_done),
        .refresh_req(refresh_req), .refresh_row(refresh_row),
        .overdue(overdue), .owed_cnt(owed_cnt)
    );

    // {tag, idle edges, pulse, req, row, owed, overdue}
    localparam int NV = 11;
    localparam logic [19:0] TBL [NV] = '{
        {4'd2, 8'd10, 1'b0, 1'b1, 3'd0, 2'd1, 1'b0}, // R2 first expiry at edge 10
        {4'd4, 8'd0,  1'b1, 1'b0, 3'd1, 2'd0, 1'b0}, // R4 served
        {4'd2, 8'd9,  1'b0, 1'b1, 3'd1, 2'd1, 1'b0}, // R2 edge 20
        {4'd5, 8'd10, 1'b0, 1'b1, 3'd1, 2'd2, 1'b1}, // R5 edge 30 behind
        {4'd5, 8'd0,  1'b1, 1'b1, 3'd2, 2'd1, 1'b0}, // R5 back to pending
        {4'd4, 8'd0,  1'b1, 1'b0, 3'd3, 2'd0, 1'b0}, // R4 cleared
        {4'd6, 8'd0,  1'b1, 1'b0, 3'd3, 2'd0, 1'b0}, // R6 done while idle
        {4'd1, 8'd6,  1'b0, 1'b0, 3'd3, 2'd0, 1'b0}, // R1 edge 39 no expiry yet
        {4'd7, 8'd0,  1'b1, 1'b1, 3'd3, 2'd1, 1'b0}, // R7 edge 40 done ignored, expiry counts
        {4'd1, 8'd9,  1'b0, 1'b1, 3'd3, 2'd1, 1'b0}, // R1 edge 49
        {4'd7, 8'd0,  1'b1, 1'b1, 3'd4, 2'd1, 1'b0}  // R7 edge 50 expire and serve
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_step(input int idle, input bit pulse);
        repeat (idle) @(negedge clk);
        if (pulse) begin
            refresh_done = 1'b1;
            @(negedge clk);
            refresh_done = 1'b0;
        end
    endtask

    task automatic serve_next();
        int guard = 0;
        while (!refresh_req && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        run_step(0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 req in reset", int'(refresh_req), 0);
        chk("R9 row in reset", int'(refresh_row), 0);
        chk("R9 owed in reset", int'(owed_cnt), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i][19:16], i);
            run_step(int'(TBL[i][15:8]), TBL[i][7]);
            chk({tag, " req"}, int'(refresh_req), int'(TBL[i][6]));
            chk({tag, " row"}, int'(refresh_row), int'(TBL[i][5:3]));
            chk({tag, " owed"}, int'(owed_cnt), int'(TBL[i][2:1]));
            chk({tag, " overdue"}, int'(overdue), int'(TBL[i][0]));
        end

        // R3 wrap: row 4 owed 1 at edge 50; serve rows 4..7
        for (int k = 0; k < 4; k++) serve_next();
        chk("R3 row wraps to 0", int'(refresh_row), 0);
        chk("R3 nothing owed after wrap", int'(owed_cnt), 0);

        // Now at edge 81. R8 saturation: expiries at 90,100,110,120
        run_step(39, 1'b0);
        chk("R8 owed saturates", int'(owed_cnt), MAXO);
        chk("R8 overdue while saturated", int'(overdue), 1);
        run_step(10, 1'b0);
        chk("R8 owed stays saturated", int'(owed_cnt), MAXO);
        run_step(0, 1'b1);
        run_step(0, 1'b1);
        chk("R5 overdue drops at one owed", int'(overdue), 0);
        run_step(0, 1'b1);
        chk("R4 all paid back", int'(refresh_req), 0);
        chk("R4 row after three serves", int'(refresh_row), 3);

        // R9 reset mid-run
        run_step(5, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 row cleared", int'(refresh_row), 0);
        chk("R9 req cleared", int'(refresh_req), 0);
        rst_n = 1'b1;
        run_step(9, 1'b0);
        chk("R1 no expiry 9 edges after release", int'(refresh_req), 0);
        run_step(1, 1'b0);
        chk("R1 expiry 10 edges after release", int'(refresh_req), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule